// File: doc/BRIEF.md
# Dual-Clock Overwriting FIFO with Collision and Threshold Flags

This block is a first-in first-out buffer that sits between two unrelated clock domains. Words are stored on the write clock and are returned in the same order on the read clock. The two clocks may run at different average rates, so the buffer is built to survive both filling and draining. When the writer gets a full lap ahead, it goes on writing and overwrites the oldest words. When the reader catches up with the writer, the read pointer stops and the output keeps showing the newest word until more data arrives.

Each pointer can be cleared to zero or loaded from a preset input, but only while the shared `ld_en` gate is high. The first accepted pointer command turns off the stop-when-empty behaviour until reset, and it raises a sticky flag that marks the threshold flags as no longer meaningful. The read domain reports a collide flag and an almost-empty flag. The write domain reports an almost-full flag. Both threshold flags are set in eightieths of the capacity and use modulo pointer distances. Each side sees the other side's pointer through a Gray-coded two-flop synchroniser, so a flag follows the far side a few destination clocks late. The input-to-output delay depends only on when each pointer was last placed, because data moves through strictly in sequence.

Top module: `ovr_fifo`

## Requirements
- R1: A word presented with `wen` high at a write-clock edge is stored. Reads with `ren` high return stored words in write order, one per read-clock edge, on the registered `rdata`.
- R2: Writes are never refused. After the writer laps the reader, a read returns the newest word written to that address.
- R3: The read side halts when the read pointer equals the synchronised write pointer and no pointer command has yet been accepted. While halted, a read leaves `rdata` and the read pointer unchanged, so the output repeats the last word. Reads resume once new writes reach the read side.
- R4: `collide` is high exactly when the read pointer equals the synchronised write pointer. Because of this, it is also high after a write lap of exactly DEPTH words.
- R5: `ae` is high when (write pointer − read pointer) mod DEPTH is less than floor(`ae_k`·DEPTH/80).
- R6: `af` is high when (read pointer − write pointer) mod DEPTH is non-zero and less than floor((80−`af_k`)·DEPTH/80). This is computed in the write domain.
- R7: While `ld_en` is high, a clear drives its pointer to 0 and a set loads its pointer from the matching preset input. Clear takes priority over set. While `ld_en` is low, clear and set have no effect.
- R8: After any accepted pointer command, the read side no longer halts on equality, and `flags_bad` goes high and stays high until reset.
- R9: After reset, `rdata` is 0, `ae` is 1, `af` is 0, `collide` is 1 and `flags_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| wen | input | 1 | Write enable |
| wdata | input | DW | Write data |
| wclr | input | 1 | Write pointer clear request |
| wset | input | 1 | Write pointer set request |
| wpreset | input | AW | Value loaded into the write pointer by a set |
| af_k | input | 7 | Almost-full threshold numerator, 0 to 80 |
| af | output | 1 | Almost-full flag, write domain |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| ren | input | 1 | Read enable |
| rclr | input | 1 | Read pointer clear request |
| rset | input | 1 | Read pointer set request |
| rpreset | input | AW | Value loaded into the read pointer by a set |
| ae_k | input | 7 | Almost-empty threshold numerator, 0 to 80 |
| rdata | output | DW | Registered read data |
| ae | output | 1 | Almost-empty flag, read domain |
| collide | output | 1 | Pointer equality flag, read domain |
| flags_bad | output | 1 | Sticky flag: a pointer command was accepted |
| ld_en | input | 1 | Gate for all pointer commands, held quasi-static |

## Verification
The hardest state to reach is a write lap. The writer must get DEPTH or more words ahead of a reader that is not reading. Along the way the almost-full band must be crossed, and the wrap must make the buffer look empty again. The bench reaches this by writing one word at a time and checking `af` at occupancy 56, 57 and 63 and `collide` at exactly 64. It then writes three more words and reads them back, expecting the overwritten contents. The bench also keeps a shadow pointer pair, a shadow memory and a flag for accepted commands, so the halt condition and the effects of commands issued with the gate open and closed can be predicted.

// File: rtl/ovr_fifo_pkg.sv
// Package: shared pointer-command type and threshold denominator.
package ovr_fifo_pkg;
    localparam int THR_DEN = 80;

    typedef enum logic [1:0] {PC_NONE, PC_CLR, PC_SET} ptr_cmd_e;

    // Decode gated clear/set requests; clear has priority.
    function automatic ptr_cmd_e ptr_decode(input logic gate, input logic clr, input logic set);
        if (!gate)     return PC_NONE;
        else if (clr)  return PC_CLR;
        else if (set)  return PC_SET;
        else           return PC_NONE;
    endfunction
endpackage

// File: rtl/ovr_gray_sync.sv
// Two-flop synchroniser for a Gray-coded (or single-bit level) bus.
// Assumes at most one bit of the input changes between destination samples.
module ovr_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage resampling into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ovr_dpram.sv
// Simple dual-port storage: clocked write port, combinational read port.
// Assumes the read address is stable in the read domain when it is sampled.
module ovr_dpram #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Store one word per enabled write-clock edge.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wd;
    end

    assign rd = mem[raddr];
endmodule

// File: rtl/ovr_wr_side.sv
// Write-domain control: write pointer, pointer commands, Gray export and
// almost-full flag from the synchronised read pointer. Writes are never blocked.
module ovr_wr_side
    import ovr_fifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          ld_en,
    input  logic          clr,
    input  logic          set,
    input  logic [AW-1:0] preset,
    input  logic [6:0]    af_k,
    input  logic [AW-1:0] rgray_s,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW-1:0] wgray,
    output logic          cmd_seen,
    output logic          af
);
    localparam int DEPTH = 1 << AW;
    localparam int TW    = AW + 8;

    ptr_cmd_e      cmd;
    logic [AW-1:0] wptr, wptr_nx, rbin, lead;
    logic [6:0]    span;
    logic [TW-1:0] th;

    assign cmd = ptr_decode(ld_en, clr, set);
    assign we  = wen && (cmd == PC_NONE);

    // Next write pointer: command first, else advance on write.
    always_comb begin
        unique case (cmd)
            PC_CLR:  wptr_nx = '0;
            PC_SET:  wptr_nx = preset;
            default: wptr_nx = we ? wptr + 1'b1 : wptr;
        endcase
    end

    // Pointer, Gray copy and sticky command marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            wgray    <= '0;
            cmd_seen <= 1'b0;
        end else begin
            wptr  <= wptr_nx;
            wgray <= wptr_nx ^ (wptr_nx >> 1);
            if (cmd != PC_NONE) cmd_seen <= 1'b1;
        end
    end

    // Gray to binary for the read pointer copy.
    always_comb begin
        rbin[AW-1] = rgray_s[AW-1];
        for (int i = AW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_s[i];
    end

    // Almost-full: read leads write by a small non-zero modulo distance.
    always_comb begin
        lead = rbin - wptr;
        span = 7'(THR_DEN) - af_k;
        th   = ({{(AW+1){1'b0}}, span} * TW'(DEPTH)) / TW'(THR_DEN);
        af   = (lead != '0) && ({8'b0, lead} < th);
    end

    assign waddr = wptr;

    AST_WPTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && !ld_en) |=> (wptr == $past(wptr) + 1'b1)); // R2
    AST_WCMD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |=> cmd_seen); // R8
endmodule

// File: rtl/ovr_rd_side.sv
// Read-domain control: read pointer with halt-on-empty, pointer commands,
// registered output, collide/almost-empty flags and flags-invalid status.
module ovr_rd_side
    import ovr_fifo_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic          ld_en,
    input  logic          clr,
    input  logic          set,
    input  logic [AW-1:0] preset,
    input  logic [6:0]    ae_k,
    input  logic [AW-1:0] wgray_s,
    input  logic          wcmd_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] rgray,
    output logic [DW-1:0] rdata,
    output logic          ae,
    output logic          collide,
    output logic          flags_bad
);
    localparam int DEPTH = 1 << AW;
    localparam int TW    = AW + 8;

    ptr_cmd_e      cmd;
    logic [AW-1:0] rptr, rptr_nx, wbin, trail;
    logic          rcmd_seen, halt, adv;
    logic [TW-1:0] th;

    assign cmd = ptr_decode(ld_en, clr, set);

    // Gray to binary for the write pointer copy.
    always_comb begin
        wbin[AW-1] = wgray_s[AW-1];
        for (int i = AW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_s[i];
    end

    assign flags_bad = rcmd_seen | wcmd_s;
    assign collide   = (rptr == wbin);
    assign halt      = !flags_bad && collide;
    assign adv       = ren && !halt && (cmd == PC_NONE);

    // Next read pointer: command first, else advance on an allowed read.
    always_comb begin
        unique case (cmd)
            PC_CLR:  rptr_nx = '0;
            PC_SET:  rptr_nx = preset;
            default: rptr_nx = adv ? rptr + 1'b1 : rptr;
        endcase
    end

    // Pointer, Gray copy, output register and sticky command marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr      <= '0;
            rgray     <= '0;
            rdata     <= '0;
            rcmd_seen <= 1'b0;
        end else begin
            rptr  <= rptr_nx;
            rgray <= rptr_nx ^ (rptr_nx >> 1);
            if (adv) rdata <= mem_q;
            if (cmd != PC_NONE) rcmd_seen <= 1'b1;
        end
    end

    // Almost-empty: read trails write by less than the threshold.
    always_comb begin
        trail = wbin - rptr;
        th    = ({{(AW+1){1'b0}}, ae_k} * TW'(DEPTH)) / TW'(THR_DEN);
        ae    = {8'b0, trail} < th;
    end

    assign raddr = rptr;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && ren && !ld_en) |=> ($stable(rdata) && $stable(rptr))); // R3
    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !ren) |=> $stable(rptr)); // R7
    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flags_bad |=> flags_bad); // R8
    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ren && !ld_en && !halt) |=> (rptr == $past(rptr) + 1'b1)); // R1
endmodule

// File: rtl/ovr_fifo.sv
// Top: dual-clock overwriting FIFO. Wires the write side, read side, storage
// and the Gray/level synchronisers between the domains.
// Assumes ld_en, ae_k and af_k are quasi-static and DEPTH is a power of two.
module ovr_fifo #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          wclr,
    input  logic          wset,
    input  logic [AW-1:0] wpreset,
    input  logic [6:0]    af_k,
    output logic          af,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          ren,
    input  logic          rclr,
    input  logic          rset,
    input  logic [AW-1:0] rpreset,
    input  logic [6:0]    ae_k,
    output logic [DW-1:0] rdata,
    output logic          ae,
    output logic          collide,
    output logic          flags_bad,
    input  logic          ld_en
);
    logic [AW-1:0] waddr, raddr, wgray, rgray, wgray_s, rgray_s;
    logic          we, wcmd, wcmd_s;
    logic [DW-1:0] mem_q;

    ovr_dpram #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wd(wdata),
        .raddr(raddr), .rd(mem_q)
    );

    ovr_wr_side #(.AW(AW)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .wen(wen), .ld_en(ld_en),
        .clr(wclr), .set(wset), .preset(wpreset), .af_k(af_k),
        .rgray_s(rgray_s), .waddr(waddr), .we(we), .wgray(wgray),
        .cmd_seen(wcmd), .af(af)
    );

    ovr_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .ren(ren), .ld_en(ld_en),
        .clr(rclr), .set(rset), .preset(rpreset), .ae_k(ae_k),
        .wgray_s(wgray_s), .wcmd_s(wcmd_s), .mem_q(mem_q),
        .raddr(raddr), .rgray(rgray), .rdata(rdata), .ae(ae),
        .collide(collide), .flags_bad(flags_bad)
    );

    ovr_gray_sync #(.W(AW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
    );

    ovr_gray_sync #(.W(AW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
    );

    ovr_gray_sync #(.W(1)) u_cmd2r (
        .clk(rclk), .rst_n(rrst_n), .d(wcmd), .q(wcmd_s)
    );
endmodule

// File: tb/ovr_fifo_tb.sv
module ovr_fifo_tb;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 0, rclk = 0;
    logic          wrst_n = 0, rrst_n = 0;
    logic          wen = 0, ren = 0, wclr = 0, wset = 0, rclr = 0, rset = 0, ld_en = 0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] wpreset = '0, rpreset = '0;
    logic [6:0]    af_k = 7'd70, ae_k = 7'd10;
    logic          af, ae, collide, flags_bad;
    logic [DW-1:0] rdata;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] sh_mem [DEPTH];
    int  wp = 0, rp = 0;
    bit  cmd_done = 0;
    logic [DW-1:0] last_q = '0;
    logic [DW-1:0] seq = 8'h10;

    always #4 wclk = ~wclk;
    initial begin #3; forever #4 rclk = ~rclk; end

    ovr_fifo #(.DW(DW), .AW(AW)) u_dut (
        .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .wdata(wdata), .wclr(wclr),
        .wset(wset), .wpreset(wpreset), .af_k(af_k), .af(af),
        .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .rclr(rclr), .rset(rset),
        .rpreset(rpreset), .ae_k(ae_k), .rdata(rdata), .ae(ae),
        .collide(collide), .flags_bad(flags_bad), .ld_en(ld_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic put(input logic [DW-1:0] d);
        @(negedge wclk); wen = 1; wdata = d;
        @(negedge wclk); wen = 0;
        sh_mem[wp % DEPTH] = d; wp = (wp + 1) % DEPTH;
    endtask

    task automatic put_n(input int n);
        for (int i = 0; i < n; i++) begin put(seq); seq = seq + 8'd1; end
    endtask

    task automatic get_chk(input string tag);
        logic [DW-1:0] exp;
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
        if (!cmd_done && rp == wp) exp = last_q;
        else begin exp = sh_mem[rp]; rp = (rp + 1) % DEPTH; end
        last_q = exp;
        check(tag, rdata, exp);
    endtask

    task automatic t_reset();
        check("R9 rdata", rdata, 0);
        check("R9 ae", ae, 1);
        check("R9 af", af, 0);
        check("R9 collide", collide, 1);
        check("R9 flags_bad", flags_bad, 0);
    endtask

    task automatic t_order();
        put_n(5); settle();
        check("R4 collide low", collide, 0);
        check("R5 ae at 5", ae, 1);
        for (int i = 0; i < 5; i++) get_chk("R1 order");
        settle();
        check("R4 collide empty", collide, 1);
    endtask

    task automatic t_halt();
        for (int i = 0; i < 3; i++) get_chk("R3 repeat last");
        put(8'h55); settle();
        get_chk("R3 resume");
    endtask

    task automatic t_thresholds();
        put_n(7); settle();
        check("R5 ae at 7", ae, 1);
        put_n(1); settle();
        check("R5 ae at 8", ae, 0);
        put_n(48); settle();
        check("R6 af at 56", af, 0);
        put_n(1); settle();
        check("R6 af at 57", af, 1);
        put_n(6); settle();
        check("R6 af at 63", af, 1);
        put_n(1); settle();
        check("R6 af at lap", af, 0);
        check("R4 collide at lap", collide, 1);
    endtask

    task automatic t_overwrite();
        put_n(3); settle();
        check("R2 collide after lap", collide, 0);
        for (int i = 0; i < 3; i++) get_chk("R2 overwritten data");
    endtask

    task automatic t_ignored();
        @(negedge rclk); rclr = 1; @(negedge rclk); rclr = 0; settle();
        check("R7 rclr gated", collide, 1);
        @(negedge wclk); wclr = 1; @(negedge wclk); wclr = 0; settle();
        check("R7 wclr gated", collide, 1);
        check("R8 flags_bad gated", flags_bad, 0);
    endtask

    task automatic t_commands();
        ld_en = 1;
        @(negedge rclk); rset = 1; rpreset = 6'd2; @(negedge rclk); rset = 0;
        rp = 2; cmd_done = 1; settle();
        check("R8 flags_bad", flags_bad, 1);
        check("R7 rset moves", collide, 0);
        get_chk("R7 read at preset");
        @(negedge wclk); wclr = 1; wset = 1; wpreset = 6'd20;
        @(negedge wclk); wclr = 0; wset = 0;
        wp = 0;
        @(negedge rclk); rclr = 1; @(negedge rclk); rclr = 0;
        rp = 0; settle();
        check("R7 clr priority", collide, 1);
        get_chk("R8 no halt 0");
        get_chk("R8 no halt 1");
        ld_en = 0;
        settle();
        check("R8 flags_bad sticky", flags_bad, 1);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        wrst_n = 1; rrst_n = 1;
        settle();
        t_reset();
        t_order();
        t_halt();
        t_thresholds();
        t_overwrite();
        t_ignored();
        t_commands();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule